// File: doc/BRIEF.md
# Power-up reset sequencer

This controller keeps a microcontroller core in reset after power is applied, after a supply brown-out and after other reset sources. Once the cause has cleared, it releases the core. A release can wait on two counters. The first is a power-up delay, counted in ticks of a slow internal RC clock enable. The second is an oscillator start-up count, counted in ticks of the external oscillator clock enable. Both tick enables are single-cycle pulses in the one system clock domain.

The supply comparator flag goes through a glitch filter before it counts as a brown-out. A brown-out that is accepted restarts the power-up delay from zero, even in the middle of a count. The oscillator-mode code decides whether the start-up count is needed, and so does the event that started the sequence. A wake-from-sleep request can hold the core for the start-up count alone. Two sticky flags record power-on and brown-out events until software clears them with a strobe.

Top module: `pwr_rst_seq`

## Requirements
- R1: While `rst_ni` is low, `core_rst_o` is 1 and both flags are 0. After `rst_ni` is released, the block runs the full power-on sequence, as in R2.
- R2: While `por_i` is 1, `core_rst_o` is 1 and `por_flag_o` is set. Once `por_i` drops, the power-up delay of `PWR_TICKS` `rc_tick_i` pulses runs, then the start-up count of R4 where it applies.
- R3: When `cfg_tmr_off_i` is 1, the power-up delay is skipped. When it is 0, the delay is used.
- R4: The start-up count is `OST_TICKS` pulses of `osc_tick_i`. It applies only when `osc_mode_i` is 3'b000, 3'b001 or 3'b010, and only after a power-on or a wake. Every other mode code skips it.
- R5: `core_rst_o` falls on the clock edge that samples the final tick of the last phase in use. Ticks of the other clock enable have no effect on the phase that is counting.
- R6: `bod_low_i` counts as a brown-out only after `BOD_FILT` consecutive high cycles while `cfg_bod_en_i` is 1. A shorter pulse, or any pulse while `cfg_bod_en_i` is 0, causes no reset and sets no flag.
- R7: A brown-out holds `core_rst_o` at 1 while `bod_low_i` stays high and sets `bod_flag_o`. After it ends, the power-up delay runs and the start-up count is skipped.
- R8: A brown-out during the power-up delay returns the block to hold. The delay then restarts from zero and needs `PWR_TICKS` further ticks.
- R9: While the core is running, `wake_i` holds `core_rst_o` at 1 for the start-up count if the mode needs one, as in R4. In any other mode `wake_i` is ignored.
- R10: `ext_rst_i` holds `core_rst_o` at 1 while it is high. `core_rst_o` is released on the next clock edge after it drops, with no delay and no start-up count.
- R11: The flags are sticky until `flag_clr_i` clears them. A set event in the same cycle as the clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| por_i | input | 1 | Power-on pulse |
| bod_low_i | input | 1 | Supply below brown-out threshold |
| ext_rst_i | input | 1 | ORed watchdog and pin reset |
| wake_i | input | 1 | Wake-from-sleep request |
| cfg_tmr_off_i | input | 1 | 1 bypasses the power-up delay |
| cfg_bod_en_i | input | 1 | 1 enables brown-out detection |
| osc_mode_i | input | 3 | Oscillator mode code |
| rc_tick_i | input | 1 | Internal RC clock tick enable |
| osc_tick_i | input | 1 | External oscillator tick enable |
| flag_clr_i | input | 1 | Clear strobe for the cause flags |
| core_rst_o | output | 1 | Active-high core reset |
| por_flag_o | output | 1 | Sticky power-on cause |
| bod_flag_o | output | 1 | Sticky brown-out cause |

## Verification
Two functions can fall in the same cycle: a flag clear strobe and a new power-on event that sets the same flag. The bench provokes this by raising `flag_clr_i` and `por_i` together for one cycle while the core is running. It then expects `por_flag_o` to read 1. A clear with no set event is expected to read 0. The bench also sweeps all eight mode codes against both delay settings and counts the ticks needed in each phase against counts it works out itself.

// File: rtl/pwr_rst_pkg.sv
package pwr_rst_pkg;
  typedef enum logic [1:0] {
    ST_HOLD = 2'd0,
    ST_PWRT = 2'd1,
    ST_OST  = 2'd2,
    ST_RUN  = 2'd3
  } seq_state_e;

  typedef enum logic [1:0] {
    CS_POR  = 2'd0,
    CS_BOD  = 2'd1,
    CS_EXT  = 2'd2,
    CS_WAKE = 2'd3
  } seq_cause_e;

  localparam int unsigned NUM_SLOW_MODES = 3;
endpackage

// File: rtl/bod_filter.sv
module bod_filter #(
  parameter int unsigned FILT = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic low_i,
  output logic det_o
);
  localparam int unsigned W = $clog2(FILT + 1);
  localparam logic [W-1:0] LIM = W'(FILT);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!en_i || !low_i)   cnt_q <= '0;
    else if (cnt_q != LIM)      cnt_q <= cnt_q + 1'b1;
  end

  // immediate drop when comparator clears
  assign det_o = en_i && low_i && (cnt_q == LIM);
endmodule

// File: rtl/tick_counter.sv
module tick_counter #(
  parameter int unsigned LIMIT = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic tick_i,
  output logic done_o
);
  localparam int unsigned W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (tick_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = run_i && tick_i && (cnt_q == LAST);
endmodule

// File: rtl/cause_flags.sv
module cause_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_por_i,
  input  logic set_bod_i,
  input  logic clr_i,
  output logic por_o,
  output logic bod_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      por_o <= 1'b0;
      bod_o <= 1'b0;
    end else begin
      por_o <= set_por_i | (por_o & ~clr_i);
      bod_o <= set_bod_i | (bod_o & ~clr_i);
    end
  end
endmodule

// File: rtl/pwr_rst_seq.sv
module pwr_rst_seq
  import pwr_rst_pkg::*;
#(
  parameter int unsigned PWR_TICKS = 72,
  parameter int unsigned OST_TICKS = 1024,
  parameter int unsigned BOD_FILT  = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       por_i,
  input  logic       bod_low_i,
  input  logic       ext_rst_i,
  input  logic       wake_i,
  input  logic       cfg_tmr_off_i,
  input  logic       cfg_bod_en_i,
  input  logic [2:0] osc_mode_i,
  input  logic       rc_tick_i,
  input  logic       osc_tick_i,
  input  logic       flag_clr_i,
  output logic       core_rst_o,
  output logic       por_flag_o,
  output logic       bod_flag_o
);
  seq_state_e state_q, state_d;
  seq_cause_e cause_q, cause_d;
  logic bod_det, pwr_done, ost_done;
  logic slow_mode, use_pwrt, need_ost;

  bod_filter #(.FILT(BOD_FILT)) i_bod_filter (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (cfg_bod_en_i),
    .low_i (bod_low_i),
    .det_o (bod_det)
  );

  tick_counter #(.LIMIT(PWR_TICKS)) i_pwr_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (state_q == ST_PWRT),
    .tick_i(rc_tick_i),
    .done_o(pwr_done)
  );

  tick_counter #(.LIMIT(OST_TICKS)) i_ost_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (state_q == ST_OST),
    .tick_i(osc_tick_i),
    .done_o(ost_done)
  );

  cause_flags i_flags (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_por_i(por_i),
    .set_bod_i(bod_det),
    .clr_i    (flag_clr_i),
    .por_o    (por_flag_o),
    .bod_o    (bod_flag_o)
  );

  assign slow_mode = (osc_mode_i < 3'(NUM_SLOW_MODES));
  assign use_pwrt  = !cfg_tmr_off_i && (cause_q == CS_POR || cause_q == CS_BOD);
  assign need_ost  = slow_mode && (cause_q == CS_POR || cause_q == CS_WAKE);

  always_comb begin
    state_d = state_q;
    cause_d = cause_q;
    if (por_i) begin
      state_d = ST_HOLD;
      cause_d = CS_POR;
    end else if (bod_det) begin
      state_d = ST_HOLD;
      // a pending power-on cause keeps its start-up count
      if (!(state_q == ST_HOLD && cause_q == CS_POR)) cause_d = CS_BOD;
    end else if (ext_rst_i) begin
      state_d = ST_HOLD;
      if (state_q != ST_HOLD) cause_d = CS_EXT;
    end else begin
      unique case (state_q)
        ST_HOLD: begin
          if (use_pwrt)      state_d = ST_PWRT;
          else if (need_ost) state_d = ST_OST;
          else               state_d = ST_RUN;
        end
        ST_PWRT: if (pwr_done) state_d = need_ost ? ST_OST : ST_RUN;
        ST_OST:  if (ost_done) state_d = ST_RUN;
        ST_RUN: begin
          if (wake_i && slow_mode) begin
            state_d = ST_OST;
            cause_d = CS_WAKE;
          end
        end
        default: state_d = ST_HOLD;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_HOLD;
      cause_q <= CS_POR;
    end else begin
      state_q <= state_d;
      cause_q <= cause_d;
    end
  end

  assign core_rst_o = (state_q != ST_RUN);
endmodule

// File: rtl/pwr_rst_seq_chk.sv
module pwr_rst_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic por_i,
  input logic ext_rst_i,
  input logic flag_clr_i,
  input logic bod_det_i,
  input logic core_rst_o,
  input logic por_flag_o,
  input logic bod_flag_o
);
  assert_por_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    por_i |=> (core_rst_o && por_flag_o));

  assert_bod_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bod_det_i |=> (core_rst_o && bod_flag_o));

  assert_ext_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_rst_i |=> core_rst_o);

  assert_flag_clear_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_clr_i && !por_i && !bod_det_i) |=> (!por_flag_o && !bod_flag_o));

  assert_flag_sticky_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (por_flag_o && !flag_clr_i) |=> por_flag_o);

  assert_bod_sticky_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bod_flag_o && !flag_clr_i) |=> bod_flag_o);
endmodule

bind pwr_rst_seq pwr_rst_seq_chk i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .por_i     (por_i),
  .ext_rst_i (ext_rst_i),
  .flag_clr_i(flag_clr_i),
  .bod_det_i (bod_det),
  .core_rst_o(core_rst_o),
  .por_flag_o(por_flag_o),
  .bod_flag_o(bod_flag_o)
);

// File: tb/test_pwr_rst_seq.sv
module test_pwr_rst_seq;
  localparam int P = 5;
  localparam int O = 6;
  localparam int F = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic por = 0, bod_low = 0, ext_rst = 0, wake = 0;
  logic tmr_off = 0, bod_en = 0, rc_tick = 0, osc_tick = 0, flag_clr = 0;
  logic [2:0] mode = 3'd0;
  logic core_rst, por_flag, bod_flag;
  int errors = 0, checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pwr_rst_seq #(.PWR_TICKS(P), .OST_TICKS(O), .BOD_FILT(F)) i_pwr_rst_seq (
    .clk_i(clk), .rst_ni(rst_n), .por_i(por), .bod_low_i(bod_low),
    .ext_rst_i(ext_rst), .wake_i(wake), .cfg_tmr_off_i(tmr_off),
    .cfg_bod_en_i(bod_en), .osc_mode_i(mode), .rc_tick_i(rc_tick),
    .osc_tick_i(osc_tick), .flag_clr_i(flag_clr), .core_rst_o(core_rst),
    .por_flag_o(por_flag), .bod_flag_o(bod_flag)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_rc();
    rc_tick = 1'b1; @(negedge clk); rc_tick = 1'b0;
  endtask

  task automatic pulse_osc();
    osc_tick = 1'b1; @(negedge clk); osc_tick = 1'b0;
  endtask

  // hold must last exactly p delay ticks then o start-up ticks
  task automatic run_seq(input int p, input int o, input string req);
    for (int i = 0; i < p; i++) begin
      chk({req, " held in delay"}, core_rst, 1);
      pulse_osc();
      pulse_rc();
    end
    for (int j = 0; j < o; j++) begin
      chk({req, " held in start-up"}, core_rst, 1);
      pulse_rc();
      pulse_osc();
    end
    chk({req, " R5 released"}, core_rst, 0);
  endtask

  task automatic bod_pulse(input int n);
    bod_low = 1'b1; cyc(n); bod_low = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    cyc(2);
    chk("R1 core_rst in reset", core_rst, 1);
    chk("R1 por_flag in reset", por_flag, 0);
    chk("R1 bod_flag in reset", bod_flag, 0);
    rst_n = 1'b1;
    cyc(2);
    run_seq(P, O, "R1");

    // R2 R3 R4 sweep of every mode code against both delay settings
    for (int m = 0; m < 8; m++) begin
      for (int t = 0; t < 2; t++) begin
        mode = 3'(m); tmr_off = t[0];
        por = 1'b1; cyc(2);
        chk("R2 held during por", core_rst, 1);
        por = 1'b0; cyc(2);
        chk("R2 por_flag set", por_flag, 1);
        run_seq((t == 1) ? 0 : P, (m < 3) ? O : 0, "R3 R4");
        flag_clr = 1'b1; cyc(1); flag_clr = 1'b0;
        chk("R11 por_flag cleared", por_flag, 0);
      end
    end

    // R6 filter and enable
    mode = 3'd0; tmr_off = 1'b0; bod_en = 1'b1;
    bod_pulse(F - 1); cyc(3);
    chk("R6 short dip no reset", core_rst, 0);
    chk("R6 short dip no flag", bod_flag, 0);
    bod_en = 1'b0;
    bod_pulse(F + 4); cyc(3);
    chk("R6 disabled no reset", core_rst, 0);
    chk("R6 disabled no flag", bod_flag, 0);
    bod_en = 1'b1;

    // R7 brown-out: delay only, start-up skipped even in slow mode
    bod_low = 1'b1; cyc(F + 3);
    chk("R7 held while low", core_rst, 1);
    chk("R7 bod_flag set", bod_flag, 1);
    bod_low = 1'b0; cyc(3);
    run_seq(P, 0, "R7");

    // R8 recurrence restarts delay
    bod_pulse(F + 2); cyc(3);
    for (int i = 0; i < P - 1; i++) pulse_rc();
    chk("R8 held before recurrence", core_rst, 1);
    bod_pulse(F + 2); cyc(3);
    run_seq(P, 0, "R8");

    // R9 wake in slow and fast modes
    mode = 3'd1;
    wake = 1'b1; cyc(1); wake = 1'b0;
    run_seq(0, O, "R9");
    mode = 3'd5;
    wake = 1'b1; cyc(1); wake = 1'b0; cyc(2);
    chk("R9 wake ignored in fast mode", core_rst, 0);

    // R10 external reset
    ext_rst = 1'b1; cyc(3);
    chk("R10 held by ext", core_rst, 1);
    ext_rst = 1'b0; cyc(1);
    chk("R10 released next edge", core_rst, 0);

    // R11 set and clear in same cycle
    flag_clr = 1'b1; cyc(1); flag_clr = 1'b0;
    chk("R11 bod_flag cleared", bod_flag, 0);
    por = 1'b1; flag_clr = 1'b1; cyc(1); flag_clr = 1'b0; por = 1'b0;
    chk("R11 set wins over clear", por_flag, 1);
    cyc(2);
    run_seq(P, 0, "R11");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule